// File: doc/BRIEF.md
# Prime-Count Interleaved Bank Mapper

This block places each incoming linear word address into a memory made of a prime number of banks, where each bank holds a power-of-two number of words. The bank is picked by the remainder of the address divided by the bank count. The row inside the bank is picked by the remainder modulo the words per bank, which is simply the address's low bits. The two counts are co-prime, so every address in range lands on its own (bank, row) pair. Strides that are powers of two, which would pile onto one bank under a plain bit split, are spread over all banks.

A requester offers an address with a valid/ready handshake. The accepted address is reduced in the same cycle, and the result waits in a one-entry request register. Each bank has a busy timer that models its access time. The held request is granted as soon as its bank is idle, so a request that returns to a busy bank stalls the interface. A grant is a one-cycle pulse carrying the bank and row. An address beyond the memory's size is answered with a one-cycle error pulse instead of a grant.

Top module: `prime_bank_mapper`

## Requirements
- R1: For an in-range address, bank_o presented with the grant pulse equals the address modulo NUM_BANKS (default 3).
- R2: row_o presented with the grant pulse equals the address modulo BANK_WORDS (default 8), i.e. its low three bits.
- R3: Over addresses 0 to NUM_BANKS*BANK_WORDS-1 (0 to 23 by default) no two addresses share a (bank_o, row_o) pair, and parameter sets whose counts are not co-prime are refused at elaboration.
- R4: A request accepted at a clock edge whose bank is idle produces grant_o high for exactly one cycle, starting at the next edge.
- R5: Two grants to the same bank are at least BUSY_CYCLES (default 10) cycles apart, and exactly that far when the second request is already waiting. While a held request's bank is busy, req_ready is low.
- R6: An address at or above NUM_BANKS*BANK_WORDS raises err_o for one cycle at the edge after acceptance, with grant_o low. It neither waits for nor starts any bank timer.
- R7: Back-to-back requests to distinct idle banks are accepted on consecutive cycles and granted on consecutive cycles.
- R8: During and right after reset req_ready is 1, grant_o and err_o are 0, and all bank timers are idle.
- R9: Grant and error pulses come out in the order the requests were accepted, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_addr | input | ADDR_W | Linear word address |
| req_ready | output | 1 | Request taken at this edge when valid |
| grant_o | output | 1 | One-cycle grant pulse |
| err_o | output | 1 | One-cycle out-of-range pulse |
| bank_o | output | BANK_W | Bank of the latest grant |
| row_o | output | ROW_W | Word within the bank of the latest grant |

## Verification
A wrong residue or row shows up on bank_o and row_o at the very next grant pulse, one edge after the offending request is taken. A bank timer that loads the wrong value or counts wrongly moves the next grant to that bank off its exact cycle, and it does so within one bank access time. The scoreboard predicts each pulse's cycle from its own bank-availability model and compares against it. A request register that drops, duplicates or reorders an entry breaks the pulse order or leaves the expected queue non-empty when the run ends.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
    localparam int DEF_BANKS  = 3;
    localparam int DEF_WORDS  = 8;
    localparam int DEF_ADDR_W = 5;
    localparam int DEF_BUSY   = 10;

    // greatest common divisor, used for the elaboration-time co-prime check
    function automatic int gcd(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        for (int i = 0; i < 64; i++) begin
            if (y != 0) begin
                t = x % y;
                x = y;
                y = t;
            end
        end
        return x;
    endfunction

    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pbm_residue.sv
// Bit-serial residue: r = (2r + bit) mod M, one conditional subtract per bit.
module pbm_residue #(
    parameter int ADDR_W  = pbm_pkg::DEF_ADDR_W,
    parameter int MODULUS = pbm_pkg::DEF_BANKS,
    parameter int RES_W   = pbm_pkg::width_of(MODULUS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [RES_W-1:0]  res_o
);
    localparam int ACC_W = RES_W + 1;
    localparam logic [ACC_W-1:0] MOD_V = ACC_W'(MODULUS);

    logic [ACC_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            acc = {acc[RES_W-1:0], addr_i[i]};
            if (acc >= MOD_V) begin
                acc = acc - MOD_V;
            end
        end
        res_o = acc[RES_W-1:0];
    end
endmodule

// File: rtl/pbm_bank_timer.sv
// One down-counter per bank; a bank is idle when its counter reads zero.
module pbm_bank_timer #(
    parameter int NUM_BANKS   = pbm_pkg::DEF_BANKS,
    parameter int BUSY_CYCLES = pbm_pkg::DEF_BUSY
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] load_i,
    output logic [NUM_BANKS-1:0] idle_o
);
    localparam int CNT_W = pbm_pkg::width_of(BUSY_CYCLES);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYCLES - 1);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [CNT_W-1:0] cnt_d;
        logic [CNT_W-1:0] cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (load_i[g]) begin
                cnt_d = RELOAD;
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - CNT_W'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign idle_o[g] = (cnt_q == '0);

        // R5: a bank is only started when its previous access has finished
        a_r5_load_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
            load_i[g] |-> (cnt_q == '0));
        // R8: a bank left alone after reset stays idle
        a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (idle_o[g] && !load_i[g]) |=> idle_o[g]);
    end
endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper #(
    parameter int NUM_BANKS   = pbm_pkg::DEF_BANKS,
    parameter int BANK_WORDS  = pbm_pkg::DEF_WORDS,
    parameter int ADDR_W      = pbm_pkg::DEF_ADDR_W,
    parameter int BUSY_CYCLES = pbm_pkg::DEF_BUSY,
    parameter int BANK_W      = pbm_pkg::width_of(NUM_BANKS),
    parameter int ROW_W       = pbm_pkg::width_of(BANK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              grant_o,
    output logic              err_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o
);
    localparam int TOTAL_WORDS = NUM_BANKS * BANK_WORDS;

    if (pbm_pkg::gcd(NUM_BANKS, BANK_WORDS) != 1) begin : g_bad_counts
        $error("bank count and words per bank must be co-prime");
    end

    typedef struct packed {
        logic              hold_v;
        logic              hold_err;
        logic [BANK_W-1:0] hold_bank;
        logic [ROW_W-1:0]  hold_row;
        logic              grant;
        logic              err;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } map_state_t;

    map_state_t s_d;
    map_state_t s_q;

    logic [BANK_W-1:0]    res_bank;
    logic [NUM_BANKS-1:0] load_vec;
    logic [NUM_BANKS-1:0] idle_vec;
    logic                 fire;
    logic                 in_range;

    pbm_residue #(
        .ADDR_W (ADDR_W),
        .MODULUS(NUM_BANKS),
        .RES_W  (BANK_W)
    ) u_residue (
        .addr_i(req_addr),
        .res_o (res_bank)
    );

    pbm_bank_timer #(
        .NUM_BANKS  (NUM_BANKS),
        .BUSY_CYCLES(BUSY_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load_vec),
        .idle_o(idle_vec)
    );

    always_comb begin
        in_range  = (32'(req_addr) < TOTAL_WORDS);
        fire      = s_q.hold_v && (s_q.hold_err || idle_vec[s_q.hold_bank]);
        req_ready = !s_q.hold_v || fire;
        load_vec  = '0;

        s_d       = s_q;
        s_d.grant = 1'b0;
        s_d.err   = 1'b0;

        if (fire) begin
            s_d.hold_v = 1'b0;
            s_d.err    = s_q.hold_err;
            s_d.grant  = !s_q.hold_err;
            if (!s_q.hold_err) begin
                s_d.bank = s_q.hold_bank;
                s_d.row  = s_q.hold_row;
                load_vec[s_q.hold_bank] = 1'b1;
            end
        end

        if (req_valid && req_ready) begin
            s_d.hold_v    = 1'b1;
            s_d.hold_err  = !in_range;
            s_d.hold_bank = res_bank;
            s_d.hold_row  = req_addr[ROW_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_o = s_q.grant;
    assign err_o   = s_q.err;
    assign bank_o  = s_q.bank;
    assign row_o   = s_q.row;

    // R1: a granted bank index is always a valid bank
    a_r1_bank_in_set: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (32'(bank_o) < NUM_BANKS));
    // R6: an error pulse never coincides with a grant
    a_r6_err_not_grant: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !grant_o);
    // R5: consecutive grants never hit the same bank when access takes >1 cycle
    a_r5_no_same_bank_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (BUSY_CYCLES > 1 && grant_o && $past(grant_o)) |-> (bank_o != $past(bank_o)));
    // R9: a taken request is held until it is answered
    a_r9_taken_is_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> s_q.hold_v);
    // R4: a pulse only follows a held request
    a_r4_pulse_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o || err_o) |-> $past(s_q.hold_v));
endmodule

// File: tb/sim_prime_bank_mapper.sv
`timescale 1ns/1ps
module sim_prime_bank_mapper;
    localparam int NB    = 3;
    localparam int WPB   = 8;
    localparam int AW    = 5;
    localparam int LAT   = 10;
    localparam int TOTAL = NB * WPB;

    typedef struct {
        bit is_err;
        int bank;
        int row;
        int when;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          grant_o;
    logic          err_o;
    logic [1:0]    bank_o;
    logic [2:0]    row_o;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   last_issue = 0;
    int   bank_next[NB];
    bit   seen[TOTAL];
    exp_t q[$];

    prime_bank_mapper #(
        .NUM_BANKS(NB), .BANK_WORDS(WPB), .ADDR_W(AW), .BUSY_CYCLES(LAT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .grant_o(grant_o), .err_o(err_o),
        .bank_o(bank_o), .row_o(row_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // driver: called at a negedge, returns at the negedge after acceptance
    task automatic send(input int a);
        exp_t e;
        int   acc;
        req_valid = 1'b1;
        req_addr  = a[AW-1:0];
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        acc      = cyc;
        e.is_err = (a >= TOTAL);
        e.bank   = a % NB;
        e.row    = a % WPB;
        e.when   = max3(acc + 1, last_issue + 1, e.is_err ? 0 : bank_next[e.bank]);
        last_issue = e.when;
        if (!e.is_err) bank_next[e.bank] = e.when + LAT;
        q.push_back(e);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (LAT + 2) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && (grant_o || err_o)) begin
            if (q.size() == 0) begin
                chk(1'b0, "R9", "pulse with nothing expected", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(cyc == e.when, "R4 R5 R7", "pulse cycle", cyc, e.when);
                if (e.is_err) begin
                    chk(err_o && !grant_o, "R6", "error pulse without grant",
                        {30'd0, err_o, grant_o}, 2);
                end else begin
                    chk(grant_o && !err_o, "R9", "grant kind", {30'd0, grant_o, err_o}, 2);
                    chk(int'(bank_o) == e.bank, "R1", "bank", int'(bank_o), e.bank);
                    chk(int'(row_o) == e.row, "R2", "row", int'(row_o), e.row);
                    if (int'(bank_o) * WPB + int'(row_o) < TOTAL)
                        seen[int'(bank_o) * WPB + int'(row_o)] = 1'b1;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected 0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) bank_next[i] = 0;
        for (int i = 0; i < TOTAL; i++) seen[i] = 1'b0;

        // R8: reset state
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready in reset", int'(req_ready), 1);
        chk(grant_o == 1'b0 && err_o == 1'b0, "R8", "pulses in reset",
            int'(grant_o) + int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready after reset", int'(req_ready), 1);

        // R1 R2 R3: full sequential sweep
        for (int a = 0; a < TOTAL; a++) send(a);
        drain();
        begin
            int n;
            n = 0;
            for (int i = 0; i < TOTAL; i++) n += int'(seen[i]);
            chk(n == TOTAL, "R3", "distinct bank/row pairs", n, TOTAL);
        end

        // R7: power-of-two stride spreads over all banks, back to back
        send(0); send(8); send(16);
        drain();
        send(7); send(11); send(12); send(9);
        drain();

        // R5: returning to a busy bank stalls ready
        send(5); send(2);
        chk(req_ready == 1'b0, "R5", "ready while bank busy", int'(req_ready), 0);
        send(20);
        drain();

        // R6: out-of-range addresses: no grant, no stall, no timer effect
        send(24); send(31); send(1); send(25); send(4);
        drain();
        send(30); send(2);
        drain();

        // mixed traffic
        for (int i = 0; i < 30; i++) send((i * 7 + 3) % 27);
        drain();

        chk(q.size() == 0, "R9", "outstanding expected pulses", q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule